// File: doc/BRIEF.md
# Serial Register Preload and Observe Chain

This block holds the state registers of a logic array and adds a test path to them. In normal operation every register loads from its functional next-state input. When a test-mode input is raised, the registers leave their functional path and form one serial shift chain. Each rising edge of a separate test clock moves a data-in bit into the head of the chain, advances every stored bit one place, and presents the tail of the chain on a data-out pad.

Bits leave in the order they entered, so a full pass of the chain length both loads a new state and dumps the old one. Feeding data-out back into data-in reads the state without changing it. An output-hold input keeps the data-out pad disabled, which gives loading without observing. A security lock input blocks the test mode completely, and the block then behaves as in normal operation.

The chain is threaded through four quadrants in turn. Inside each quadrant it visits the two registers of each I/O cell, and after every second I/O cell it visits one buried register.

Top module: `preload_scan_chain`

## Requirements
- R1: A synchronous active-high reset clears every register to 0 and leaves `sdo_oe` low.
- R2: While the test mode is inactive (`tm_en` low or `sec_lock` high), a cycle with `func_we` high loads `func_d` into `reg_q` at the next clock edge, and `tck` has no effect.
- R3: While the test mode is active, `func_we` and `func_d` are ignored, and `reg_q` holds between test-clock rising edges.
- R4: Each rising edge of `tck` in test mode causes one shift. Chain position 0 takes `sdi`, and position p takes the old value of position p-1. Registers are indexed per 32-bit quadrant q: I/O cell k first register at q*32+k, its second register at q*32+13+k, and buried register b at q*32+26+b. Within a quadrant the positions run second then first register of cell 0, then of cell 1, then buried 0, then cells 2 and 3 and buried 1, and so on up to cells 10 and 11 and buried 5, and end with cell 12. Quadrant q occupies positions q*32 to q*32+31.
- R5: `sdo` presents the bit at chain position 127 one clock after each shift. After 128 pulses the old contents have left in FIFO order, the bit at position 127 first.
- R6: With `sdi` taken from `sdo` on each pulse, 128 pulses return the contents in order and leave `reg_q` unchanged.
- R7: `sdo_oe` is high only while the test mode is active and `sdo_hold` is low. `sdo` reads 0 when `sdo_oe` is low.
- R8: With `sec_lock` high, `tck` pulses do not shift and `sdo_oe` stays low.
- R9: Only a low-to-high transition of `tck` shifts. A `tck` already high when the mode is entered does not shift, and a long high pulse shifts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| func_we | input | 1 | Functional load enable |
| func_d | input | 128 | Functional next state |
| reg_q | output | 128 | Register contents |
| tm_en | input | 1 | Test-mode request |
| sec_lock | input | 1 | Security lock; blocks the test mode |
| tck | input | 1 | Test clock, sampled by clk |
| sdi | input | 1 | Serial data in |
| sdo_hold | input | 1 | Keeps the data-out pad disabled |
| sdo | output | 1 | Serial data out (chain tail) |
| sdo_oe | output | 1 | Pad enable for sdo; low means high impedance |

## Verification
The hardest thing to observe is the chain order. One shift only shows the head bit and the tail bit. The bench therefore loads a known functional state, preloads a full 128-bit pattern, and compares every dumped bit and every register against an independent position map. It then loops the whole pattern back to confirm the FIFO order. Entering the mode with `tck` already high, and holding `tck` high for several clocks, tests the edge qualification with a single-shift expectation.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [1:0] {
        SLOT_IO_A  = 2'd0,
        SLOT_IO_B  = 2'd1,
        SLOT_BURY  = 2'd2
    } slot_e;

    typedef struct packed {
        logic active;
        logic shift;
        logic hold_out;
    } scan_ctl_t;

    function automatic int slot_index(slot_e s, int base, int n_io, int k);
        case (s)
            SLOT_IO_A: return base + k;
            SLOT_IO_B: return base + n_io + k;
            default:   return base + 2 * n_io + k;
        endcase
    endfunction

    // Map a chain position to the flat register index it occupies.
    function automatic int chain_to_reg(int pos, int n_io, int n_bur);
        int per_q;
        int base;
        int r;
        int c;
        int idx;
        per_q = 2 * n_io + n_bur;
        base  = (pos / per_q) * per_q;
        r     = pos % per_q;
        c     = 0;
        idx   = 0;
        for (int k = 0; k < n_io; k++) begin
            if (c == r) idx = slot_index(SLOT_IO_B, base, n_io, k);
            c++;
            if (c == r) idx = slot_index(SLOT_IO_A, base, n_io, k);
            c++;
            if ((k % 2 == 1) && (k / 2 < n_bur)) begin
                if (c == r) idx = slot_index(SLOT_BURY, base, n_io, k / 2);
                c++;
            end
        end
        for (int b = n_io / 2; b < n_bur; b++) begin
            if (c == r) idx = slot_index(SLOT_BURY, base, n_io, b);
            c++;
        end
        return idx;
    endfunction

endpackage

// File: rtl/psc_tclk_edge.sv
module psc_tclk_edge
    import psc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tm_en,
    input  logic      sec_lock,
    input  logic      tck,
    input  logic      sdo_hold,
    output scan_ctl_t ctl
);

    logic tck_q;

    always_ff @(posedge clk) begin
        if (rst) tck_q <= 1'b1;
        else     tck_q <= tck;
    end

    always_comb begin
        ctl.active   = tm_en & ~sec_lock;
        ctl.shift    = ctl.active & tck & ~tck_q;
        ctl.hold_out = sdo_hold;
    end

    assert_single_shift_R9: assert property (@(posedge clk) disable iff (rst)
        ctl.shift |=> !ctl.shift);

    assert_lock_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        sec_lock |-> !ctl.shift);

endmodule

// File: rtl/psc_reg_bank.sv
module psc_reg_bank
    import psc_pkg::*;
#(
    parameter int N_QUAD = 4,
    parameter int N_IO   = 13,
    parameter int N_BUR  = 6
) (
    input  logic                                clk,
    input  logic                                rst,
    input  scan_ctl_t                           ctl,
    input  logic                                sdi,
    input  logic                                func_we,
    input  logic [N_QUAD*(2*N_IO+N_BUR)-1:0]    func_d,
    output logic [N_QUAD*(2*N_IO+N_BUR)-1:0]    reg_q,
    output logic                                tail
);

    localparam int PER_Q = 2 * N_IO + N_BUR;
    localparam int N     = N_QUAD * PER_Q;
    localparam int HEAD  = chain_to_reg(0, N_IO, N_BUR);
    localparam int TAIL  = chain_to_reg(N - 1, N_IO, N_BUR);

    logic [N-1:0] shifted;

    for (genvar p = 0; p < N; p++) begin : g_link
        localparam int DST = chain_to_reg(p, N_IO, N_BUR);
        if (p == 0) begin : g_head
            assign shifted[DST] = sdi;
        end else begin : g_body
            localparam int SRC = chain_to_reg(p - 1, N_IO, N_BUR);
            assign shifted[DST] = reg_q[SRC];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else if (ctl.active) begin
            if (ctl.shift) reg_q <= shifted;
        end else if (func_we) begin
            reg_q <= func_d;
        end
    end

    assign tail = reg_q[TAIL];

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> reg_q == '0);

    assert_func_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctl.active && func_we) |=> reg_q == $past(func_d));

    assert_hold_between_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl.active && !ctl.shift) |=> $stable(reg_q));

    assert_head_load_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.shift |=> reg_q[HEAD] == $past(sdi));

endmodule

// File: rtl/psc_dout.sv
module psc_dout
    import psc_pkg::*;
(
    input  scan_ctl_t ctl,
    input  logic      tail,
    output logic      sdo,
    output logic      sdo_oe
);

    always_comb begin
        sdo_oe = ctl.active & ~ctl.hold_out;
        sdo    = sdo_oe ? tail : 1'b0;
    end

endmodule

// File: rtl/preload_scan_chain.sv
module preload_scan_chain
    import psc_pkg::*;
#(
    parameter int N_QUAD = 4,
    parameter int N_IO   = 13,
    parameter int N_BUR  = 6
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             func_we,
    input  logic [N_QUAD*(2*N_IO+N_BUR)-1:0] func_d,
    output logic [N_QUAD*(2*N_IO+N_BUR)-1:0] reg_q,
    input  logic                             tm_en,
    input  logic                             sec_lock,
    input  logic                             tck,
    input  logic                             sdi,
    input  logic                             sdo_hold,
    output logic                             sdo,
    output logic                             sdo_oe
);

    localparam int N        = N_QUAD * (2 * N_IO + N_BUR);
    localparam int PRE_TAIL = chain_to_reg(N - 2, N_IO, N_BUR);

    scan_ctl_t ctl;
    logic      tail;

    psc_tclk_edge u_ctl (
        .clk      (clk),
        .rst      (rst),
        .tm_en    (tm_en),
        .sec_lock (sec_lock),
        .tck      (tck),
        .sdo_hold (sdo_hold),
        .ctl      (ctl)
    );

    psc_reg_bank #(.N_QUAD(N_QUAD), .N_IO(N_IO), .N_BUR(N_BUR)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .sdi     (sdi),
        .func_we (func_we),
        .func_d  (func_d),
        .reg_q   (reg_q),
        .tail    (tail)
    );

    psc_dout u_out (
        .ctl    (ctl),
        .tail   (tail),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    assert_fifo_out_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.shift && sdo_oe) |=> (!sdo_oe || sdo == $past(reg_q[PRE_TAIL])));

    assert_pad_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> !sdo);

endmodule

// File: tb/sim_preload_scan_chain.sv
module sim_preload_scan_chain;

    localparam int N = 128;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         func_we = 1'b0;
    logic [N-1:0] func_d = '0;
    logic [N-1:0] reg_q;
    logic         tm_en = 1'b0;
    logic         sec_lock = 1'b0;
    logic         tck = 1'b0;
    logic         sdi = 1'b0;
    logic         sdo_hold = 1'b0;
    logic         sdo;
    logic         sdo_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [N-1:0] fpat, pat, expv, got, snap;

    always #5 clk = ~clk;

    preload_scan_chain u0 (
        .clk(clk), .rst(rst), .func_we(func_we), .func_d(func_d), .reg_q(reg_q),
        .tm_en(tm_en), .sec_lock(sec_lock), .tck(tck), .sdi(sdi),
        .sdo_hold(sdo_hold), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // Chain position -> register index, written from the R4 text.
    function automatic int pos_map(int pos);
        int q, r, g, o, base;
        q = pos / 32; r = pos % 32; base = q * 32;
        if (r < 30) begin
            g = r / 5; o = r % 5;
            case (o)
                0: return base + 13 + 2 * g;
                1: return base + 2 * g;
                2: return base + 13 + 2 * g + 1;
                3: return base + 2 * g + 1;
                default: return base + 26 + g;
            endcase
        end
        return (r == 30) ? base + 25 : base + 12;
    endfunction

    function automatic logic [N-1:0] one_shift(logic [N-1:0] old, logic b);
        logic [N-1:0] nv;
        nv[pos_map(0)] = b;
        for (int p = 1; p < N; p++) nv[pos_map(p)] = old[pos_map(p - 1)];
        return nv;
    endfunction

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(logic b);
        @(negedge clk); tck = 1'b1; sdi = b;
        @(negedge clk); tck = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 regs", reg_q, '0);
        chk("R1 oe", {127'b0, sdo_oe}, '0);
    endtask

    task automatic t_functional();
        fpat = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk); func_d = fpat; func_we = 1'b1;
        @(negedge clk); func_we = 1'b0; func_d = ~fpat;
        chk("R2 load", reg_q, fpat);
        pulse(1'b1); pulse(1'b0);
        chk("R2 tck ignored", reg_q, fpat);
        chk("R2 oe off", {127'b0, sdo_oe}, '0);
    endtask

    task automatic t_mode_hold();
        @(negedge clk); tm_en = 1'b1; func_we = 1'b1; func_d = ~fpat;
        repeat (4) @(negedge clk);
        func_we = 1'b0;
        chk("R3 functional ignored", reg_q, fpat);
    endtask

    task automatic t_preload();
        logic [N-1:0] dump, exp_dump;
        pat = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        chk("R7 oe on", {127'b0, sdo_oe}, {127'b0, 1'b1});
        for (int j = 0; j < N; j++) begin
            dump[j] = sdo;
            exp_dump[j] = fpat[pos_map(N - 1 - j)];
            pulse(pat[j]);
        end
        for (int j = 0; j < N; j++) expv[pos_map(N - 1 - j)] = pat[j];
        chk("R5 fifo dump", dump, exp_dump);
        chk("R4 chain order", reg_q, expv);
    endtask

    task automatic t_loopback();
        for (int j = 0; j < N; j++) begin
            got[j] = sdo;
            pulse(sdo);
        end
        chk("R6 loop data", got, pat);
        chk("R6 regs intact", reg_q, expv);
    endtask

    task automatic t_out_hold();
        @(negedge clk); sdo_hold = 1'b1;
        @(negedge clk);
        chk("R7 hold oe", {127'b0, sdo_oe}, '0);
        chk("R7 hold data", {127'b0, sdo}, '0);
        pulse(1'b1);
        chk("R7 shift under hold", reg_q, one_shift(expv, 1'b1));
        expv = one_shift(expv, 1'b1);
        @(negedge clk); sdo_hold = 1'b0;
    endtask

    task automatic t_edge();
        @(negedge clk); tm_en = 1'b0;
        @(negedge clk); tck = 1'b1;
        @(negedge clk); tm_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 high at entry", reg_q, expv);
        tck = 1'b0;
        @(negedge clk); tck = 1'b1; sdi = 1'b0;
        repeat (6) @(negedge clk);
        tck = 1'b0;
        @(negedge clk);
        chk("R9 one shift", reg_q, one_shift(expv, 1'b0));
        expv = one_shift(expv, 1'b0);
    endtask

    task automatic t_lock();
        @(negedge clk); sec_lock = 1'b1;
        @(negedge clk);
        chk("R8 oe", {127'b0, sdo_oe}, '0);
        pulse(1'b1); pulse(1'b0);
        chk("R8 no shift", reg_q, expv);
        snap = ~expv;
        @(negedge clk); func_d = snap; func_we = 1'b1;
        @(negedge clk); func_we = 1'b0;
        chk("R8 R2 functional under lock", reg_q, snap);
        @(negedge clk); sec_lock = 1'b0; tm_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_functional();
        t_mode_hold();
        t_preload();
        t_loopback();
        t_out_hold();
        t_edge();
        t_lock();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule